// File: doc/BRIEF.md
# Quad-Pumped Bus Inversion Codec

This block sits next to the pins of a 64-bit, active-low, source-synchronous data bus that moves four transfers in each bus clock. Its transmit path takes four 64-bit logical words packed into one 256-bit beat. For each sub-phase and each 16-bit group it decides whether to send that group inverted. It then drives the electrical data lines and one active-low inversion flag per group and sub-phase. Its receive path takes electrical data and flags for all four sub-phases and rebuilds the logical words.

A logical 1 is an asserted bit, which on this bus means an electrically low line. A group whose logical value has more than half its bits set would pull most of its lines low. The encoder sends such a group inverted and asserts its flag, which pulls the flag line low. The decision is made on its own for every group of every sub-phase.

Each path is one register stage with a valid/ready handshake on both sides. A beat is taken on a clock edge where the input valid and ready are both high. An output beat stays exactly as it is while its valid is high and its ready is low. The input ready is low only while the stage holds a beat that the downstream side is refusing. Because of this, a full stage whose output is being drained can take a new beat on the same edge.

Top module: `quad_dbi_codec`

## Requirements
- R1: Beat layout. Sub-phase p occupies bits 64p+63:64p, with sub-phase 0 in the least significant position. Group g of that sub-phase occupies bits 64p+16g+15:64p+16g. Its flag is bit 4p+g of the 16-bit flag vector, so flag 0 covers bits 15:0, flag 1 covers bits 31:16, flag 2 covers bits 47:32 and flag 3 covers bits 63:48.
- R2: A group whose logical value has 9 or more bits set is driven uninverted on the pins (pin bits equal the logical bits). Its flag pin is driven 0, the asserted level.
- R3: A group whose logical value has 8 or fewer bits set is driven as the bitwise complement of the logical bits. Its flag pin is driven 1, the deasserted level.
- R4: No group presented on the transmit pins ever has more than 8 bits at 0.
- R5: The inversion choice for one group and sub-phase does not depend on any other group or sub-phase in the same beat.
- R6: The receive path outputs the complement of the pin bits for a group whose flag pin is 1, and the pin bits unchanged for a group whose flag pin is 0. Passing the transmit output through the receive path therefore returns the original word.
- R7: A transmit beat accepted at a clock edge appears on the transmit outputs, with valid high, right after that edge.
- R8: While the transmit output is valid and not ready, its data and flags stay stable and the transmit input ready is low.
- R9: The receive path follows the same one-cycle latency and back-pressure rules as R7 and R8.
- R10: During and after reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Logical beat offered for transmit |
| tx_in_ready | output | 1 | Transmit stage can take a beat |
| tx_in_word | input | 256 | Four logical 64-bit sub-phase words |
| tx_out_valid | output | 1 | Pin beat available |
| tx_out_ready | input | 1 | Pin side takes the beat |
| tx_pin_data | output | 256 | Electrical data for the four sub-phases |
| tx_pin_flag_n | output | 16 | Active-low inversion flags, one per group and sub-phase |
| rx_in_valid | input | 1 | Pin beat offered for decoding |
| rx_in_ready | output | 1 | Receive stage can take a beat |
| rx_pin_data | input | 256 | Electrical data received for four sub-phases |
| rx_pin_flag_n | input | 16 | Received active-low inversion flags |
| rx_out_valid | output | 1 | Logical beat available |
| rx_out_ready | input | 1 | Consumer takes the logical beat |
| rx_out_word | output | 256 | Restored logical words |

## Verification
The bench builds the codec with its default shape: 16-bit groups, four groups per word and four sub-phases. These are the values the bus uses. Group patterns with exactly 8 and exactly 9 set bits can then sit side by side in one beat, so the threshold edge and the independence of each group's choice are exercised in a single transfer. The same build also lets a stalled beat be held on each path while a second one waits at the input, and lets a drain and a new load happen on the same edge.

// File: rtl/quad_dbi_pkg.sv
package quad_dbi_pkg;
  localparam int DEF_GRP_W = 16;
  localparam int DEF_GRP_N = 4;
  localparam int DEF_PH_N  = 4;

  // Strictly more than half of the group set means invert.
  function automatic int invert_above(input int grp_w);
    return grp_w / 2;
  endfunction
endpackage

// File: rtl/dbi_group_enc.sv
module dbi_group_enc
  import quad_dbi_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W
) (
  input  logic [GRP_W-1:0] logic_grp,
  output logic [GRP_W-1:0] pin_grp,
  output logic             pin_flag_n
);
  localparam int CW = $clog2(GRP_W + 1);
  localparam logic [CW-1:0] LIMIT = CW'(invert_above(GRP_W));

  logic [CW-1:0] n_set;
  logic          do_inv;

  always_comb begin
    n_set = '0;
    for (int b = 0; b < GRP_W; b++) begin
      n_set = n_set + CW'(logic_grp[b]);
    end
    do_inv = (n_set > LIMIT);
  end

  // Active-low lines: plain send is the complement, an inverted send cancels it.
  assign pin_grp    = do_inv ? logic_grp : ~logic_grp;
  assign pin_flag_n = ~do_inv;
endmodule

// File: rtl/dbi_group_dec.sv
module dbi_group_dec
  import quad_dbi_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W
) (
  input  logic [GRP_W-1:0] pin_grp,
  input  logic             pin_flag_n,
  output logic [GRP_W-1:0] logic_grp
);
  // Undo active-low first, then undo inversion when the flag is asserted (low).
  logic [GRP_W-1:0] high_true;
  assign high_true = ~pin_grp;
  assign logic_grp = pin_flag_n ? high_true : ~high_true;
endmodule

// File: rtl/dbi_stage.sv
module dbi_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/quad_dbi_codec.sv
module quad_dbi_codec
  import quad_dbi_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W,
  parameter int GRP_N = DEF_GRP_N,
  parameter int PH_N  = DEF_PH_N
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_in_valid,
  output logic                         tx_in_ready,
  input  logic [GRP_W*GRP_N*PH_N-1:0]  tx_in_word,
  output logic                         tx_out_valid,
  input  logic                         tx_out_ready,
  output logic [GRP_W*GRP_N*PH_N-1:0]  tx_pin_data,
  output logic [GRP_N*PH_N-1:0]        tx_pin_flag_n,
  input  logic                         rx_in_valid,
  output logic                         rx_in_ready,
  input  logic [GRP_W*GRP_N*PH_N-1:0]  rx_pin_data,
  input  logic [GRP_N*PH_N-1:0]        rx_pin_flag_n,
  output logic                         rx_out_valid,
  input  logic                         rx_out_ready,
  output logic [GRP_W*GRP_N*PH_N-1:0]  rx_out_word
);
  localparam int WORD_W = GRP_W * GRP_N;
  localparam int BUS_W  = WORD_W * PH_N;
  localparam int FLAG_W = GRP_N * PH_N;

  logic [BUS_W-1:0]  enc_data;
  logic [FLAG_W-1:0] enc_flag_n;
  logic [BUS_W-1:0]  dec_word;

  for (genvar p = 0; p < PH_N; p++) begin : g_phase
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      localparam int LO = p * WORD_W + g * GRP_W;
      localparam int FI = p * GRP_N + g;

      dbi_group_enc #(.GRP_W(GRP_W)) u_enc (
        .logic_grp  (tx_in_word[LO +: GRP_W]),
        .pin_grp    (enc_data[LO +: GRP_W]),
        .pin_flag_n (enc_flag_n[FI])
      );

      dbi_group_dec #(.GRP_W(GRP_W)) u_dec (
        .pin_grp    (rx_pin_data[LO +: GRP_W]),
        .pin_flag_n (rx_pin_flag_n[FI]),
        .logic_grp  (dec_word[LO +: GRP_W])
      );
    end
  end

  dbi_stage #(.W(BUS_W + FLAG_W)) u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({enc_flag_n, enc_data}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  ({tx_pin_flag_n, tx_pin_data})
  );

  dbi_stage #(.W(BUS_W)) u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (dec_word),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_word)
  );
endmodule

// File: rtl/quad_dbi_codec_chk.sv
module quad_dbi_codec_chk #(
  parameter int GRP_W = 16,
  parameter int GRP_N = 4,
  parameter int PH_N  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tx_in_valid,
  input logic                         tx_in_ready,
  input logic [GRP_W*GRP_N*PH_N-1:0]  tx_in_word,
  input logic                         tx_out_valid,
  input logic                         tx_out_ready,
  input logic [GRP_W*GRP_N*PH_N-1:0]  tx_pin_data,
  input logic [GRP_N*PH_N-1:0]        tx_pin_flag_n,
  input logic                         rx_in_valid,
  input logic                         rx_in_ready,
  input logic [GRP_W*GRP_N*PH_N-1:0]  rx_pin_data,
  input logic [GRP_N*PH_N-1:0]        rx_pin_flag_n,
  input logic                         rx_out_valid,
  input logic                         rx_out_ready,
  input logic [GRP_W*GRP_N*PH_N-1:0]  rx_out_word
);
  localparam int WORD_W = GRP_W * GRP_N;

  for (genvar p = 0; p < PH_N; p++) begin : g_phase
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      localparam int LO = p * WORD_W + g * GRP_W;
      localparam int FI = p * GRP_N + g;

      assert_grp_low_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> ($countones(~tx_pin_data[LO +: GRP_W]) <= GRP_W / 2));

      assert_inv_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_pin_flag_n[FI]) |->
          ($countones(~tx_pin_data[LO +: GRP_W]) < GRP_W / 2));
    end
  end

  assert_tx_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready) |=> tx_out_valid);

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=>
      (tx_out_valid && $stable(tx_pin_data) && $stable(tx_pin_flag_n)));

  assert_tx_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |-> !tx_in_ready);

  assert_rx_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready) |=> rx_out_valid);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_word)));

  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(!rst_n) |-> (!tx_out_valid && !rx_out_valid));
endmodule

bind quad_dbi_codec quad_dbi_codec_chk #(
  .GRP_W(GRP_W), .GRP_N(GRP_N), .PH_N(PH_N)
) u_chk (.*);

// File: tb/quad_dbi_codec_bench.sv
module quad_dbi_codec_bench;
  localparam int GW = 16;
  localparam int GN = 4;
  localparam int PN = 4;
  localparam int BW = GW * GN * PN;
  localparam int FW = GN * PN;
  localparam int NV = 8;

  // {expected inversion, group pattern}
  localparam logic [GW:0] VEC [NV] = '{
    {1'b0, 16'h0000}, {1'b1, 16'hFFFF}, {1'b0, 16'h00FF}, {1'b1, 16'h01FF},
    {1'b0, 16'h8000}, {1'b1, 16'hFFFE}, {1'b0, 16'h5555}, {1'b1, 16'hD555}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [BW-1:0] tx_in_word = '0, rx_pin_data = '0;
  logic [FW-1:0] rx_pin_flag_n = '1;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [BW-1:0] tx_pin_data, rx_out_word;
  logic [FW-1:0] tx_pin_flag_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  quad_dbi_codec u_quad_dbi_codec (.*);

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_enc(input logic [BW-1:0] w, output logic [BW-1:0] d,
                                  output logic [FW-1:0] f);
    for (int k = 0; k < FW; k++) begin
      logic [GW-1:0] s;
      s = w[k*GW +: GW];
      if ($countones(s) >= 9) begin d[k*GW +: GW] = s;  f[k] = 1'b0; end
      else                    begin d[k*GW +: GW] = ~s; f[k] = 1'b1; end
    end
  endfunction

  function automatic bit low_ok(input logic [BW-1:0] d);
    for (int k = 0; k < FW; k++)
      if ($countones(~d[k*GW +: GW]) > 8) return 1'b0;
    return 1'b1;
  endfunction

  task automatic send_tx(input logic [BW-1:0] w);
    @(negedge clk); tx_in_word = w; tx_in_valid = 1'b1;
    @(negedge clk); tx_in_valid = 1'b0;
  endtask

  task automatic send_rx(input logic [BW-1:0] d, input logic [FW-1:0] f);
    @(negedge clk); rx_pin_data = d; rx_pin_flag_n = f; rx_in_valid = 1'b1;
    @(negedge clk); rx_in_valid = 1'b0;
  endtask

  // Encode, check pins, then feed pins back through the decoder.
  task automatic round_trip(input logic [BW-1:0] w, input string tag);
    logic [BW-1:0] ed;
    logic [FW-1:0] ef;
    logic [BW-1:0] pd;
    logic [FW-1:0] pf;
    ref_enc(w, ed, ef);
    send_tx(w);
    chk(tx_out_valid, {"R7 tx valid ", tag}, BW'(tx_out_valid), BW'(1));
    chk(tx_pin_data == ed, {"R2/R3 pin data ", tag}, tx_pin_data, ed);
    chk(tx_pin_flag_n == ef, {"R1 flags ", tag}, BW'(tx_pin_flag_n), BW'(ef));
    chk(low_ok(tx_pin_data), {"R4 low count ", tag}, tx_pin_data, ed);
    pd = tx_pin_data; pf = tx_pin_flag_n;
    send_rx(pd, pf);
    chk(rx_out_valid, {"R9 rx valid ", tag}, BW'(rx_out_valid), BW'(1));
    chk(rx_out_word == w, {"R6 round trip ", tag}, rx_out_word, w);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [BW-1:0] w, a_d, b_d;
    logic [FW-1:0] a_f, b_f, ef;

    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready && rx_in_ready,
        "R10 in reset", BW'({tx_out_valid, rx_out_valid, tx_in_ready, rx_in_ready}),
        BW'(4'b0011));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready && rx_in_ready,
        "R10 after reset", BW'({tx_out_valid, rx_out_valid, tx_in_ready, rx_in_ready}),
        BW'(4'b0011));

    // Table walk: each beat mixes all eight patterns, shifted per row (R5).
    for (int i = 0; i < NV; i++) begin
      w = '0; ef = '0;
      for (int p = 0; p < PN; p++)
        for (int g = 0; g < GN; g++) begin
          int k;
          k = (i + p * GN + g) % NV;
          w[(p*GN+g)*GW +: GW] = VEC[k][GW-1:0];
          ef[p*GN+g] = ~VEC[k][GW];
        end
      round_trip(w, $sformatf("row %0d", i));
      ref_enc(w, a_d, a_f);
      chk(a_f == ef, $sformatf("R5 table flags row %0d", i), BW'(a_f), BW'(ef));
    end

    // Corner beats: all ones, all zeros, single-group threshold neighbours.
    round_trip('1, "all ones");
    round_trip('0, "all zeros");
    w = '0; w[5*GW +: GW] = 16'h01FF; w[6*GW +: GW] = 16'h00FF;
    round_trip(w, "R5 lone 9 next to lone 8");
    chk(tx_pin_flag_n == 16'hFFDF, "R5 only flag 5 asserted",
        BW'(tx_pin_flag_n), BW'(16'hFFDF));

    // Decoder-only corners (R6).
    send_rx('1, '1);
    chk(rx_out_word == '0, "R6 idle lines decode to zero", rx_out_word, '0);
    send_rx('0, '0);
    chk(rx_out_word == '0, "R6 low lines with flags asserted", rx_out_word, '0);
    send_rx('0, '1);
    chk(rx_out_word == '1, "R6 low lines with flags clear", rx_out_word, '1);

    // Random beats.
    for (int r = 0; r < 24; r++) begin
      for (int q = 0; q < BW / 32; q++) w[q*32 +: 32] = $urandom;
      round_trip(w, $sformatf("random %0d", r));
    end

    // Transmit back-pressure (R8, R7).
    w = {8{32'h0F0F_F0F0}};
    ref_enc(w, a_d, a_f);
    tx_out_ready = 1'b0;
    send_tx(w);
    @(negedge clk); tx_in_word = '1; tx_in_valid = 1'b1;
    chk(!tx_in_ready, "R8 tx input stalled", BW'(tx_in_ready), BW'(0));
    @(negedge clk);
    chk(tx_out_valid && tx_pin_data == a_d && tx_pin_flag_n == a_f,
        "R8 tx held", tx_pin_data, a_d);
    ref_enc('1, b_d, b_f);
    tx_out_ready = 1'b1;
    @(negedge clk); tx_in_valid = 1'b0;
    chk(tx_out_valid && tx_pin_data == b_d && tx_pin_flag_n == b_f,
        "R7 drain and load same edge", tx_pin_data, b_d);
    @(negedge clk);
    chk(!tx_out_valid, "R7 tx empties", BW'(tx_out_valid), BW'(0));

    // Receive back-pressure (R9).
    rx_out_ready = 1'b0;
    send_rx('1, '1);
    @(negedge clk); rx_pin_data = '0; rx_pin_flag_n = '1; rx_in_valid = 1'b1;
    chk(!rx_in_ready, "R9 rx input stalled", BW'(rx_in_ready), BW'(0));
    @(negedge clk);
    chk(rx_out_valid && rx_out_word == '0, "R9 rx held", rx_out_word, '0);
    rx_out_ready = 1'b1;
    @(negedge clk); rx_in_valid = 1'b0;
    chk(rx_out_valid && rx_out_word == '1, "R9 rx drain and load", rx_out_word, '1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule